// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight raw interrupt request lines into a register of pending requests. Every line is sampled once per clock. A per-line trigger-mode bit decides how the line is read. In level mode the pending bit tracks the line. In edge mode the pending bit is set by a low-to-high transition between two samples and then holds. The block keeps the level seen at the previous sample for each line, so that it can find those transitions.

A downstream priority stage reads the pending bits and names one line back through a single-cycle acknowledge strobe. The acknowledge clears an edge-mode request and has no effect on a level-mode request. A reinitialise strobe drops edge-mode requests, keeps level-mode requests and forgets the remembered levels. The trigger-mode register can be written and read back. A fixed per-instance write mask forces some lines to stay in edge mode. Two registered status vectors report which lines recorded a new request and whether each line was masked at that sample.

Top module: `irq_req_latch`

## Requirements
- R1: While reset is high and on the first cycle after it, pending_o, newreq_o, masked_o and trig_rdata_o are all zero. After reset every line is in edge mode.
- R2: In level mode (trigger bit i = 1), pending_o[i] after a clock edge equals the value req_i[i] had at that edge. This holds for both low and high values.
- R3: In edge mode (trigger bit i = 0), pending_o[i] becomes 1 at an edge where req_i[i] is 1 and the previous sample was 0. A low input does not clear it. A line held high sets it only once.
- R4: The remembered level is updated at every sample in both modes. Suppose a line is high while in level mode and is then switched to edge mode. Once the request is acknowledged, it produces no new request while it stays high.
- R5: An acknowledge (ack_valid_i with line index ack_line_i) clears pending bit ack_line_i only if that line is in edge mode. A level-mode bit is unchanged. If a rising edge and an acknowledge of the same edge-mode line come at the same edge, the bit ends up clear.
- R6: When trig_we_i is high, the trigger register takes trig_wdata_i AND TRIG_WMASK at the edge. trig_rdata_o shows it from the next cycle on. Bit i applies to line i, and 1 means level mode.
- R7: A reinitialise strobe clears all edge-mode pending bits, keeps the level-mode pending bits and zeroes every remembered level. An edge-mode line still held high therefore records a new request at the next sample.
- R8: newreq_o[i] is high for exactly the cycle after an edge at which pending bit i went from 0 to 1. masked_o[i] reports mask_i[i] as sampled at that same edge.
- R9: mask_i has no effect on whether a request is captured into pending_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Raw request lines, synchronous to clk |
| mask_i | input | 8 | Per-line mask, reported only |
| trig_we_i | input | 1 | Trigger-mode register write strobe |
| trig_wdata_i | input | 8 | Trigger-mode write data, 1 = level mode |
| trig_rdata_o | output | 8 | Trigger-mode register readback |
| ack_valid_i | input | 1 | Single-cycle acknowledge strobe |
| ack_line_i | input | 3 | Index of the line being acknowledged |
| reinit_i | input | 1 | Single-cycle reinitialise strobe |
| pending_o | output | 8 | Pending request bits |
| newreq_o | output | 8 | One-cycle flag: request newly recorded |
| masked_o | output | 8 | Mask state sampled with the same edge |

## Verification
The bench drives short and long pulses on edge-mode lines, which separates edge capture from level following. It uses the same pulse shapes on level-mode lines, so that a latch that fails to track a falling input shows up. Acknowledges go to an edge line held high, to a level line, and to an edge line in the same cycle as its rising edge. These tell a correct clear apart from a missing clear, a clear applied in the wrong mode, and the wrong set/clear precedence. A line is switched from level to edge mode while it is held high, which shows whether the remembered level was kept up in both modes. A reinitialise with a mix of pending edge and level bits shows which of them are dropped and that edge detection starts again.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic pend;
        logic prev;
    } line_state_t;

    // Next state of one request line for one sample.
    function automatic line_state_t line_step(
        line_state_t cur,
        trig_mode_e  mode,
        logic        req,
        logic        ack,
        logic        reinit
    );
        line_state_t nxt;
        if (reinit) begin
            nxt.pend = (mode == TRIG_LEVEL) ? cur.pend : 1'b0;
            nxt.prev = 1'b0;
        end else if (mode == TRIG_LEVEL) begin
            nxt.pend = req;
            nxt.prev = req;
        end else begin
            nxt.pend = (cur.pend | (req & ~cur.prev)) & ~ack;
            nxt.prev = req;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/irq_trig_reg.sv
module irq_trig_reg #(
    parameter int unsigned           NUM_LINES  = 8,
    parameter logic [NUM_LINES-1:0]  TRIG_WMASK = '1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (we) begin
            mode_q <= wdata & TRIG_WMASK;
        end
    end
endmodule

// File: rtl/irq_ack_decode.sv
module irq_ack_decode #(
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 valid,
    input  logic [IDX_W-1:0]     line,
    output logic [NUM_LINES-1:0] hit
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
        assign hit[g] = valid && (line == IDX_W'(g));
    end
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
    import irq_latch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic level_mode,
    input  logic ack_hit,
    input  logic reinit,
    output logic pend,
    output logic newreq
);
    line_state_t st_q;
    line_state_t st_d;

    always_comb begin
        st_d = line_step(st_q, trig_mode_e'(level_mode), req, ack_hit, reinit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            newreq <= 1'b0;
        end else begin
            st_q   <= st_d;
            newreq <= st_d.pend & ~st_q.pend;
        end
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int unsigned           NUM_LINES  = 8,
    parameter logic [NUM_LINES-1:0]  TRIG_WMASK = 8'hF8,
    localparam int unsigned          IDX_W      = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic                 trig_we_i,
    input  logic [NUM_LINES-1:0] trig_wdata_i,
    output logic [NUM_LINES-1:0] trig_rdata_o,
    input  logic                 ack_valid_i,
    input  logic [IDX_W-1:0]     ack_line_i,
    input  logic                 reinit_i,
    output logic [NUM_LINES-1:0] pending_o,
    output logic [NUM_LINES-1:0] newreq_o,
    output logic [NUM_LINES-1:0] masked_o
);
    logic [NUM_LINES-1:0] mode_q;
    logic [NUM_LINES-1:0] ack_hit;
    logic [NUM_LINES-1:0] mask_q;

    irq_trig_reg #(
        .NUM_LINES  (NUM_LINES),
        .TRIG_WMASK (TRIG_WMASK)
    ) u_trig (
        .clk    (clk),
        .rst    (rst),
        .we     (trig_we_i),
        .wdata  (trig_wdata_i),
        .mode_q (mode_q)
    );

    irq_ack_decode #(
        .NUM_LINES (NUM_LINES)
    ) u_ack (
        .valid (ack_valid_i),
        .line  (ack_line_i),
        .hit   (ack_hit)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irq_line_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .req        (req_i[g]),
            .level_mode (mode_q[g]),
            .ack_hit    (ack_hit[g]),
            .reinit     (reinit_i),
            .pend       (pending_o[g]),
            .newreq     (newreq_o[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_i;
        end
    end

    assign trig_rdata_o = mode_q;
    assign masked_o     = mask_q;
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
    parameter int unsigned           NUM_LINES  = 8,
    parameter logic [NUM_LINES-1:0]  TRIG_WMASK = 8'hF8,
    localparam int unsigned          IDX_W      = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] req_i,
    input logic                 ack_valid_i,
    input logic [IDX_W-1:0]     ack_line_i,
    input logic                 reinit_i,
    input logic [NUM_LINES-1:0] trig_rdata_o,
    input logic [NUM_LINES-1:0] pending_o,
    input logic [NUM_LINES-1:0] newreq_o
);
    logic                 live;
    logic [NUM_LINES-1:0] ack_vec;

    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    assign ack_vec = ack_valid_i ? (NUM_LINES'(1) << ack_line_i) : '0;

    // R2
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        live && !$past(reinit_i) |->
            ((pending_o & $past(trig_rdata_o)) == ($past(req_i) & $past(trig_rdata_o))));

    // R5
    edge_ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        live |-> ((pending_o & ~$past(trig_rdata_o) & $past(ack_vec)) == '0));

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        live && !$past(reinit_i) |->
            (($past(pending_o) & ~$past(trig_rdata_o) & ~$past(ack_vec) & ~pending_o) == '0));

    // R6
    trig_wmask_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_rdata_o & ~TRIG_WMASK) == '0);

    // R7
    reinit_drop_chk: assert property (@(posedge clk) disable iff (rst)
        live && $past(reinit_i) |->
            ((pending_o & ~$past(trig_rdata_o)) == '0) &&
            ((pending_o & $past(trig_rdata_o)) == ($past(pending_o) & $past(trig_rdata_o))));

    // R8
    newreq_pend_chk: assert property (@(posedge clk) disable iff (rst)
        live |-> ((newreq_o & ~pending_o) == '0) && ((newreq_o & $past(pending_o)) == '0));
endmodule

bind irq_req_latch irq_req_latch_chk #(
    .NUM_LINES  (NUM_LINES),
    .TRIG_WMASK (TRIG_WMASK)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_i),
    .ack_valid_i  (ack_valid_i),
    .ack_line_i   (ack_line_i),
    .reinit_i     (reinit_i),
    .trig_rdata_o (trig_rdata_o),
    .pending_o    (pending_o),
    .newreq_o     (newreq_o)
);

// File: tb/irq_req_latch_bench.sv
module irq_req_latch_bench;
    localparam logic [7:0] WMASK = 8'hF8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_i = '0, mask_i = '0, trig_wdata_i = '0;
    logic       trig_we_i = 1'b0, ack_valid_i = 1'b0, reinit_i = 1'b0;
    logic [2:0] ack_line_i = '0;
    logic [7:0] trig_rdata_o, pending_o, newreq_o, masked_o;

    always #5 clk = ~clk;

    irq_req_latch u_irq_req_latch (
        .clk(clk), .rst(rst), .req_i(req_i), .mask_i(mask_i),
        .trig_we_i(trig_we_i), .trig_wdata_i(trig_wdata_i), .trig_rdata_o(trig_rdata_o),
        .ack_valid_i(ack_valid_i), .ack_line_i(ack_line_i), .reinit_i(reinit_i),
        .pending_o(pending_o), .newreq_o(newreq_o), .masked_o(masked_o)
    );

    typedef struct {
        logic [7:0] pend;
        logic [7:0] newreq;
        logic [7:0] masked;
        logic [7:0] trig;
        string      tag;
    } exp_t;

    exp_t  exp_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag   = "R1";

    // Reference state, derived from the requirements
    logic [7:0] m_pend = '0, m_prev = '0, m_trig = '0;

    task automatic chk(input string t, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    // Driver: apply one sample and push the expected result
    task automatic cyc(input logic [7:0] req, input logic [7:0] mask, input logic we,
                       input logic [7:0] wd, input logic av, input logic [2:0] al, input logic ri);
        exp_t e;
        logic [7:0] np, nr;
        @(negedge clk);
        req_i = req; mask_i = mask; trig_we_i = we; trig_wdata_i = wd;
        ack_valid_i = av; ack_line_i = al; reinit_i = ri;
        for (int i = 0; i < 8; i++) begin
            if (ri) begin
                np[i] = m_trig[i] ? m_pend[i] : 1'b0;
            end else if (m_trig[i]) begin
                np[i] = req[i];
            end else begin
                np[i] = m_pend[i] | (req[i] & ~m_prev[i]);
                if (av && al == 3'(i)) np[i] = 1'b0;
            end
            nr[i] = np[i] & ~m_pend[i];
        end
        m_prev = ri ? 8'h00 : req;
        m_pend = np;
        if (we) m_trig = wd & WMASK;
        e.pend = np; e.newreq = nr; e.masked = mask; e.trig = m_trig; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input logic [7:0] req, input logic [7:0] mask);
        cyc(req, mask, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0);
    endtask

    // Monitor: compare each produced result with the queued expectation
    always @(posedge clk) begin
        if (!rst) begin
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "pending", pending_o, e.pend);
                chk(e.tag, "newreq",  newreq_o,  e.newreq);
                chk(e.tag, "masked",  masked_o,  e.masked);
                chk(e.tag, "trig",    trig_rdata_o, e.trig);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "pending in reset", pending_o, 8'h00);
        chk("R1", "trig in reset", trig_rdata_o, 8'h00);
        rst = 1'b0;
        @(posedge clk); #2;
        chk("R1", "pending after reset", pending_o, 8'h00);
        chk("R1", "newreq after reset", newreq_o, 8'h00);

        // R6: write is filtered by the write mask
        tag = "R6";
        cyc(8'h00, 8'h00, 1'b1, 8'h07, 1'b0, 3'd0, 1'b0);
        cyc(8'h00, 8'h00, 1'b1, 8'hFF, 1'b0, 3'd0, 1'b0);
        idle(8'h00, 8'h00);

        // R2: level lines 4 and 6 follow the input
        tag = "R2";
        idle(8'h10, 8'h00);
        idle(8'h50, 8'h00);
        idle(8'h40, 8'h00);
        idle(8'h00, 8'h00);

        // R3: edge line 0, short pulse then long hold
        tag = "R3";
        idle(8'h01, 8'h00);
        idle(8'h00, 8'h00);
        idle(8'h00, 8'h00);
        idle(8'h01, 8'h00);
        idle(8'h01, 8'h00);

        // R5: ack edge line held high clears, no re-set; ack level line ignored
        tag = "R5";
        cyc(8'h11, 8'h00, 1'b0, 8'h00, 1'b1, 3'd0, 1'b0);
        idle(8'h11, 8'h00);
        cyc(8'h11, 8'h00, 1'b0, 8'h00, 1'b1, 3'd4, 1'b0);
        idle(8'h00, 8'h00);
        // R5: rising edge on edge line 1 with same-cycle ack
        cyc(8'h02, 8'h00, 1'b0, 8'h00, 1'b1, 3'd1, 1'b0);
        idle(8'h02, 8'h00);
        idle(8'h00, 8'h00);

        // R9 / R8: masked lines still capture; status reports the mask
        tag = "R9";
        idle(8'h08, 8'h08);
        idle(8'h0C, 8'hFF);
        tag = "R8";
        idle(8'h84, 8'h80);
        idle(8'h84, 8'h00);
        cyc(8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 3'd2, 1'b0);

        // R4: line 5 high in level mode, then switched to edge mode
        tag = "R4";
        idle(8'h20, 8'h00);
        cyc(8'h20, 8'h00, 1'b1, 8'hD8, 1'b0, 3'd0, 1'b0);
        idle(8'h20, 8'h00);
        cyc(8'h20, 8'h00, 1'b0, 8'h00, 1'b1, 3'd5, 1'b0);
        idle(8'h20, 8'h00);
        idle(8'h00, 8'h00);

        // R7: reinit with edge line 0 held high and level line 6 high
        tag = "R7";
        cyc(8'h00, 8'h00, 1'b1, 8'hFF, 1'b0, 3'd0, 1'b0);
        idle(8'h41, 8'h00);
        cyc(8'h41, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b1);
        idle(8'h41, 8'h00);
        idle(8'h00, 8'h00);

        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule